// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits next to the fetch stage of a small in-order processor and closes inner loops without a compare-and-branch. A loop-setup instruction writes an iteration count and the address of the first body instruction into dedicated registers. Every fetched instruction carries a one-bit end-of-loop marker. When a marked instruction is fetched and more than one iteration remains, the block sends the fetch unit back to the loop start in the same cycle. No bubble or stall is added. When the last iteration ends, the program counter falls through to the next address.

The block is purely a next-address selector with its own loop state. The core presents the current fetch address, the marker bit and the setup strobe with its operands. It takes `next_pc_o` as the address of the following fetch. One loop level is held. A second setup while a loop runs replaces the first and raises a sticky flag.

Top module: `hwloop_ctrl`

## Requirements
- R1: While reset is applied, and after it is released, the loop is inactive, the remaining count reads 0 and the nesting flag reads 0.
- R2: In a cycle with `setup_i` high, `next_pc_o` is `pc_i + 1`. After that edge, the remaining count equals `setup_count_i` and the loop start equals `setup_start_i`. The loop is active exactly when the loaded count is non-zero.
- R3: In a cycle with the loop active, `eol_i` high, `setup_i` low and a remaining count above 1, `next_pc_o` equals the stored loop start in that same cycle. The count is one lower after the edge and the loop stays active.
- R4: In a cycle with the loop active, `eol_i` high, `setup_i` low and a remaining count of exactly 1, `next_pc_o` is `pc_i + 1`. After the edge the loop is inactive and the count is 0.
- R5: A setup with count 0 leaves the loop inactive. Later marked instructions then have no effect: `next_pc_o` is `pc_i + 1` and the state stays unchanged.
- R6: In a cycle with `eol_i` and `setup_i` both low, `next_pc_o` is `pc_i + 1` and the count, active state and nesting flag do not change.
- R7: A setup while the loop is active overwrites the count and the start address and sets `nest_ovf_o`. The flag stays set until reset.
- R8: When `setup_i` and `eol_i` are high in the same cycle, the setup takes priority. `next_pc_o` is `pc_i + 1` and the count is not decremented.
- R9: The sequential address `pc_i + 1` wraps modulo 2^AW, so the all-ones address is followed by 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| pc_i | input | AW | Address of the instruction fetched this cycle |
| eol_i | input | 1 | End-of-loop marker of the fetched instruction |
| setup_i | input | 1 | Fetched instruction is a loop setup |
| setup_count_i | input | CW | Iteration count carried by the setup |
| setup_start_i | input | AW | Loop start address carried by the setup |
| next_pc_o | output | AW | Address of the next fetch |
| loop_active_o | output | 1 | A loop is in progress |
| iter_left_o | output | CW | Remaining iteration count |
| nest_ovf_o | output | 1 | Sticky flag: a setup arrived while a loop was active |

## Verification
The redirect address is combinational, so `next_pc_o` is due in the same cycle as the marker or setup that causes it. The count, active state and nesting flag change exactly one edge later. The bench drives inputs on the falling edge, compares `next_pc_o` shortly after, and then advances its reference model on the rising edge. The registered outputs are checked at the next falling edge, against the state the model reached. The fetch address fed back to the block is always the model's expected next address, so a wrong redirect shows up at once as an address mismatch.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

  // Action taken on the loop registers in the current cycle
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,  // no change
    ACT_LOAD = 2'd1,  // setup instruction writes count and start
    ACT_ITER = 2'd2,  // marker seen, more passes remain: jump back
    ACT_EXIT = 2'd3   // marker seen on the final pass: fall through
  } loop_act_e;

endpackage

// File: rtl/hwloop_rst_sync.sv
module hwloop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/hwloop_decide.sv
module hwloop_decide
  import hwloop_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          active_i,
  input  logic [CW-1:0] count_i,
  input  logic          eol_i,
  input  logic          setup_i,
  output loop_act_e     act_o,
  output logic          redirect_o
);

  localparam logic [CW-1:0] ONE = CW'(1);

  always_comb begin
    act_o = ACT_HOLD;
    if (setup_i) begin
      act_o = ACT_LOAD;
    end else if (eol_i && active_i) begin
      if (count_i > ONE) begin
        act_o = ACT_ITER;
      end else begin
        act_o = ACT_EXIT;
      end
    end
  end

  assign redirect_o = (act_o == ACT_ITER);

endmodule

// File: rtl/hwloop_state.sv
module hwloop_state
  import hwloop_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  loop_act_e     act_i,
  input  logic [CW-1:0] setup_count_i,
  input  logic [AW-1:0] setup_start_i,
  output logic          active_o,
  output logic [CW-1:0] count_o,
  output logic [AW-1:0] start_o,
  output logic          ovf_o
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic          active_q, active_d;
  logic [CW-1:0] count_q, count_d;
  logic [AW-1:0] start_q, start_d;
  logic          ovf_q, ovf_d;
  logic          state_en;
  logic          start_en;

  // next-state
  always_comb begin
    active_d = active_q;
    count_d  = count_q;
    start_d  = start_q;
    ovf_d    = ovf_q;
    unique case (act_i)
      ACT_LOAD: begin
        count_d  = setup_count_i;
        start_d  = setup_start_i;
        active_d = |setup_count_i;
        ovf_d    = ovf_q | active_q;
      end
      ACT_ITER: begin
        count_d = count_q - ONE;
      end
      ACT_EXIT: begin
        count_d  = '0;
        active_d = 1'b0;
      end
      default: begin
      end
    endcase
  end

  assign state_en = (act_i != ACT_HOLD);
  assign start_en = (act_i == ACT_LOAD);

  // loop count, active bit and sticky flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      count_q  <= '0;
      ovf_q    <= 1'b0;
    end else if (state_en) begin
      active_q <= active_d;
      count_q  <= count_d;
      ovf_q    <= ovf_d;
    end
  end

  // return address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
    end else if (start_en) begin
      start_q <= start_d;
    end
  end

  assign active_o = active_q;
  assign count_o  = count_q;
  assign start_o  = start_q;
  assign ovf_o    = ovf_q;

endmodule

// File: rtl/hwloop_pcgen.sv
module hwloop_pcgen #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] pc_i,
  input  logic          redirect_i,
  input  logic [AW-1:0] start_i,
  output logic [AW-1:0] next_pc_o
);

  localparam logic [AW-1:0] STEP = AW'(1);

  logic [AW-1:0] seq_pc;

  assign seq_pc = pc_i + STEP;

  always_comb begin
    if (redirect_i) begin
      next_pc_o = start_i;
    end else begin
      next_pc_o = seq_pc;
    end
  end

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwloop_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc_i,
  input  logic          eol_i,
  input  logic          setup_i,
  input  logic [CW-1:0] setup_count_i,
  input  logic [AW-1:0] setup_start_i,
  output logic [AW-1:0] next_pc_o,
  output logic          loop_active_o,
  output logic [CW-1:0] iter_left_o,
  output logic          nest_ovf_o
);

  logic          rst_sync_n;
  loop_act_e     act;
  logic          redirect;
  logic          active;
  logic [CW-1:0] count;
  logic [AW-1:0] start;
  logic          ovf;

  hwloop_rst_sync #(
    .STAGES(RST_STAGES)
  ) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  hwloop_decide #(
    .CW(CW)
  ) u_decide (
    .active_i  (active),
    .count_i   (count),
    .eol_i     (eol_i),
    .setup_i   (setup_i),
    .act_o     (act),
    .redirect_o(redirect)
  );

  hwloop_state #(
    .AW(AW),
    .CW(CW)
  ) u_state (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .act_i        (act),
    .setup_count_i(setup_count_i),
    .setup_start_i(setup_start_i),
    .active_o     (active),
    .count_o      (count),
    .start_o      (start),
    .ovf_o        (ovf)
  );

  hwloop_pcgen #(
    .AW(AW)
  ) u_pcgen (
    .pc_i      (pc_i),
    .redirect_i(redirect),
    .start_i   (start),
    .next_pc_o (next_pc_o)
  );

  assign loop_active_o = active;
  assign iter_left_o   = count;
  assign nest_ovf_o    = ovf;

endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_ok,
  input logic [AW-1:0] pc_i,
  input logic          eol_i,
  input logic          setup_i,
  input logic [CW-1:0] setup_count_i,
  input logic [AW-1:0] next_pc_o,
  input logic          loop_active_o,
  input logic [CW-1:0] iter_left_o,
  input logic          nest_ovf_o
);

  localparam logic [CW-1:0] C1 = CW'(1);
  localparam logic [AW-1:0] A1 = AW'(1);

  // R2
  load_count_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    setup_i |=> (iter_left_o == $past(setup_count_i)) &&
                (loop_active_o == ($past(setup_count_i) != '0)));

  // R3
  iter_dec_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (loop_active_o && eol_i && !setup_i && iter_left_o > C1)
      |=> loop_active_o && (iter_left_o == $past(iter_left_o) - C1));

  // R4
  last_pass_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (loop_active_o && eol_i && !setup_i && iter_left_o == C1)
      |-> next_pc_o == pc_i + A1);

  // R4
  exit_clear_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (loop_active_o && eol_i && !setup_i && iter_left_o == C1)
      |=> !loop_active_o && iter_left_o == '0);

  // R5
  idle_marker_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!loop_active_o && !setup_i) |-> next_pc_o == pc_i + A1);

  // R6
  plain_step_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!eol_i && !setup_i) |=> $stable(iter_left_o) && $stable(loop_active_o) &&
                             $stable(nest_ovf_o));

  // R7
  nest_set_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (loop_active_o && setup_i) |=> nest_ovf_o);

  // R7
  nest_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    nest_ovf_o |=> nest_ovf_o);

  // R8
  setup_seq_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    setup_i |-> next_pc_o == pc_i + A1);

endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(
  .AW(AW),
  .CW(CW)
) u_chk (
  .clk          (clk),
  .rst_ok       (rst_sync_n),
  .pc_i         (pc_i),
  .eol_i        (eol_i),
  .setup_i      (setup_i),
  .setup_count_i(setup_count_i),
  .next_pc_o    (next_pc_o),
  .loop_active_o(loop_active_o),
  .iter_left_o  (iter_left_o),
  .nest_ovf_o   (nest_ovf_o)
);

// File: tb/hwloop_ctrl_tb.sv
`timescale 1ns/1ps
module hwloop_ctrl_tb;

  localparam int AW = 16;
  localparam int CW = 8;
  localparam int AMASK = (1 << AW) - 1;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] pc_i;
  logic          eol_i;
  logic          setup_i;
  logic [CW-1:0] setup_count_i;
  logic [AW-1:0] setup_start_i;
  logic [AW-1:0] next_pc_o;
  logic          loop_active_o;
  logic [CW-1:0] iter_left_o;
  logic          nest_ovf_o;

  hwloop_ctrl #(.AW(AW), .CW(CW)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pc_i         (pc_i),
    .eol_i        (eol_i),
    .setup_i      (setup_i),
    .setup_count_i(setup_count_i),
    .setup_start_i(setup_start_i),
    .next_pc_o    (next_pc_o),
    .loop_active_o(loop_active_o),
    .iter_left_o  (iter_left_o),
    .nest_ovf_o   (nest_ovf_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model state
  bit m_act;
  int m_cnt;
  int m_start;
  bit m_ovf;
  int pc_v;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_act = 0; m_cnt = 0; m_start = 0; m_ovf = 0;
  endtask

  // One fetch: drive, check outputs, advance model at the edge
  task automatic step(input string req, input bit e, input bit s, input int c, input int a);
    int exp_next;
    @(negedge clk);
    chk(req, "loop_active", int'(loop_active_o), int'(m_act));
    chk(req, "iter_left", int'(iter_left_o), m_cnt);
    chk(req, "nest_ovf", int'(nest_ovf_o), int'(m_ovf));
    pc_i = AW'(pc_v); eol_i = e; setup_i = s;
    setup_count_i = CW'(c); setup_start_i = AW'(a);
    if (!s && e && m_act && m_cnt > 1) exp_next = m_start;
    else exp_next = (pc_v + 1) & AMASK;
    #1;
    chk(req, "next_pc", int'(next_pc_o), exp_next);
    @(posedge clk);
    if (s) begin
      if (m_act) m_ovf = 1;
      m_cnt = c; m_start = a; m_act = (c != 0);
    end else if (e && m_act) begin
      if (m_cnt > 1) m_cnt = m_cnt - 1;
      else begin m_cnt = 0; m_act = 0; end
    end
    pc_v = exp_next;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    eol_i = 0; setup_i = 0; setup_count_i = '0; setup_start_i = '0; pc_i = '0;
    model_reset();
    repeat (2) @(negedge clk);
    // R1: state cleared while held in reset
    chk("R1", "loop_active", int'(loop_active_o), 0);
    chk("R1", "iter_left", int'(iter_left_o), 0);
    chk("R1", "nest_ovf", int'(nest_ovf_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // run a body [first..last] until fall-through past last
  task automatic run_body(input string req, input int last, input int cap);
    for (int i = 0; i < cap && pc_v != ((last + 1) & AMASK); i++) begin
      step(req, pc_v == last, 0, 0, 0);
    end
    chk(req, "fallthrough_pc", pc_v, (last + 1) & AMASK);
  endtask

  initial begin
    rst_n = 1'b1;
    do_reset();

    // R6: plain fetches
    pc_v = 'h0100;
    step("R6", 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0);
    // R2: setup, 3 passes of body 0x0103..0x0104
    step("R2", 0, 1, 3, 'h0103);
    // R3 / R4: redirect twice, then exit
    run_body("R3", 'h0104, 20);
    step("R4", 0, 0, 0, 0);

    // R5: zero count, marker ignored afterwards
    step("R5", 0, 1, 0, 'h0200);
    step("R5", 1, 0, 0, 0);
    step("R5", 1, 0, 0, 0);

    // single-instruction body, count 4
    step("R3", 0, 1, 4, pc_v + 1);
    run_body("R3", pc_v, 20);

    // R7: nested setup overwrites, flag sticks
    step("R7", 0, 1, 5, 'h0300);
    step("R7", 0, 1, 2, pc_v + 1);
    run_body("R7", pc_v + 1, 20);
    step("R7", 0, 1, 1, 'h0400);
    step("R7", 1, 0, 0, 0);

    // R8: setup and marker together while active
    step("R8", 0, 1, 3, pc_v + 1);
    step("R8", 1, 1, 6, 'h0500);
    step("R8", 0, 0, 0, 0);

    // R9: wrap of sequential address, and redirect around it
    pc_v = AMASK;
    step("R9", 0, 0, 0, 0);
    pc_v = AMASK - 1;
    step("R9", 0, 1, 2, AMASK);
    run_body("R9", AMASK, 20);

    // R1: reset clears sticky flag and loop state
    step("R1", 0, 1, 9, 'h0600);
    do_reset();
    step("R1", 1, 0, 0, 0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule